// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for a single peripheral, whether it is supplied with power and whether it is supplied with a clock. It uses two inputs for that decision. The first is the operating mode of the device: Run, Sleep or Deep-Sleep. The second is a small set of software-written control bits. There is one gating bit per operating mode. There is also one power-retain bit, which decides what happens when the gating bit for the current mode is clear. When that bit is set, the peripheral keeps power but loses its clock, so its state is retained. When that bit is clear, the peripheral loses both power and clock, and its state is lost.

The controller tracks whether the peripheral has been without power. When power comes back, it issues a one-cycle reset pulse to the peripheral, so the peripheral starts from a known state. Power can come back in two ways: a mode change can select a set gating bit, or software can set the power-retain bit. The block can be instantiated once per peripheral. Software reaches the control bits through a plain register write and read port.

Top module: `pwr_clk_gate`

## Requirements
- R1: The gating bit that applies is chosen by `op_mode`. Code 0 (Run) selects gating bit 0, code 1 (Sleep) selects bit 1, and code 2 (Deep-Sleep) selects bit 2. Code 3 behaves exactly like code 2.
- R2: When the gating bit that applies is 1, `pwr_en` and `clk_en` are both 1, whatever value the power-retain bit holds.
- R3: When the gating bit that applies is 0 and the power-retain bit is 0, `pwr_en` and `clk_en` are both 0.
- R4: When the gating bit that applies is 0 and the power-retain bit is 1, `pwr_en` is 1 and `clk_en` is 0.
- R5: `per_rst` is a single-cycle high pulse. It appears in exactly the cycle in which `pwr_en` returns to 1 after having been 0, and at no other time. This holds whether power returns through a mode change or through a write to the power-retain bit. If both causes land in the same cycle, only one pulse is issued.
- R6: The power register sits at address 1. Its bit 0 is the power-retain bit: it can be read and written, and its reset value is 1. Bits 31:1 of this register read as 0, and writes to them have no effect.
- R7: The gating register sits at address 0. Bit 0 is the Run gating bit, bit 1 is the Sleep gating bit, and bit 2 is the Deep-Sleep gating bit. All three reset to 0. Bits 31:3 read as 0 and ignore writes. Reads from any other address return 0, and writes to any other address change nothing.
- R8: While reset is held and after it is released, `pwr_en` is 1, `clk_en` is 0 and `per_rst` is 0, until a mode or register change says otherwise.
- R9: `clk_en` is never 1 while `pwr_en` is 0.
- R10: All outputs are registered. A new `op_mode` value shows on the outputs after the next clock edge. A register write takes effect at the clock edge on which `reg_wr` is sampled, and shows on the outputs one edge after that. `reg_rdata` is combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_mode | input | 2 | Device operating mode (0 Run, 1 Sleep, 2 and 3 Deep-Sleep) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pwr_en | output | 1 | Peripheral power enable |
| clk_en | output | 1 | Peripheral clock enable |
| per_rst | output | 1 | One-cycle peripheral reset pulse |

## Verification
Two events can restore power in the same clock edge: a mode change onto a set gating bit, and a write of 1 to the power-retain bit. The bench provokes this by leaving the peripheral unpowered, then changing `op_mode` and writing the power register in one cycle. It judges that exactly one `per_rst` pulse comes out, with no second pulse when the write becomes visible on the edge that follows. A second same-cycle case is also tested. Here the mode change cuts power on the same edge where a write of 1 to the power-retain bit is sampled. The expected result is one cycle unpowered, followed by a single pulse on the next edge.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DEEP  = 2'd2,
    MODE_DEEP2 = 2'd3
  } op_mode_e;

  localparam int N_MODES   = 3;
  localparam int GATE_ADDR = 0;
  localparam int PWR_ADDR  = 1;
endpackage

// File: rtl/pgc_regs.sv
module pgc_regs
  import pgc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_MODES-1:0] gate,
  output logic              retain
);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(GATE_ADDR);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_ADDR);

  logic [N_MODES-1:0] gate_q;
  logic               retain_q;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:N_MODES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= '0;
      retain_q <= 1'b1;
    end else if (wr) begin
      if (addr == A_GATE) gate_q   <= wdata[N_MODES-1:0];
      if (addr == A_PWR)  retain_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_GATE)     rdata[N_MODES-1:0] = gate_q;
    else if (addr == A_PWR) rdata[0]           = retain_q;
  end

  assign gate   = gate_q;
  assign retain = retain_q;
endmodule

// File: rtl/pgc_select.sv
module pgc_select
  import pgc_pkg::*;
(
  input  logic [1:0]         mode,
  input  logic [N_MODES-1:0] gate,
  input  logic               retain,
  output logic               pwr_nx,
  output logic               clk_nx
);
  logic [N_MODES-1:0] hit;
  logic               gate_cur;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    if (m == N_MODES - 1) begin : g_last
      assign hit[m] = (int'(mode) >= m);
    end else begin : g_exact
      assign hit[m] = (int'(mode) == m);
    end
  end

  assign gate_cur = |(hit & gate);
  assign clk_nx   = gate_cur;
  assign pwr_nx   = gate_cur | retain;
endmodule

// File: rtl/pgc_outreg.sv
module pgc_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_nx,
  input  logic clk_nx,
  output logic pwr_en,
  output logic clk_en,
  output logic per_rst
);
  logic pwr_q, clk_q, lost_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q   <= 1'b1;
      clk_q   <= 1'b0;
      lost_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pwr_q   <= pwr_nx;
      clk_q   <= clk_nx & pwr_nx;
      pulse_q <= pwr_nx & lost_q;
      lost_q  <= ~pwr_nx;
    end
  end

  assign pwr_en  = pwr_q;
  assign clk_en  = clk_q;
  assign per_rst = pulse_q;
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pgc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwr_en,
  output logic              clk_en,
  output logic              per_rst
);
  logic [N_MODES-1:0] gate;
  logic               retain;
  logic               pwr_nx, clk_nx;

  pgc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .gate(gate), .retain(retain)
  );

  pgc_select u_sel (
    .mode(op_mode), .gate(gate), .retain(retain),
    .pwr_nx(pwr_nx), .clk_nx(clk_nx)
  );

  pgc_outreg u_out (
    .clk(clk), .rst_n(rst_n), .pwr_nx(pwr_nx), .clk_nx(clk_nx),
    .pwr_en(pwr_en), .clk_en(clk_en), .per_rst(per_rst)
  );
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en,
  input logic clk_en,
  input logic per_rst
);
  p_clk_needs_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> pwr_en);

  p_pulse_on_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> per_rst);

  p_pulse_only_on_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_rst |-> (pwr_en && !$past(pwr_en)));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_rst |=> !per_rst);
endmodule

bind pwr_clk_gate pgc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .clk_en(clk_en), .per_rst(per_rst)
);

// File: tb/test_pwr_clk_gate.sv
`timescale 1ns/1ps
module test_pwr_clk_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_mode = 2'd0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        pwr_en, clk_en, per_rst;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed { logic p; logic c; logic r; } exp_t;
  exp_t exp_q[$];

  logic [2:0] sh_gate = 3'b000;
  logic       sh_ret  = 1'b1;
  logic       prev_p  = 1'b1;

  always #2.5 clk = ~clk;

  pwr_clk_gate i_pwr_clk_gate (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwr_en(pwr_en), .clk_en(clk_en), .per_rst(per_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; expectations come from the requirements.
  task automatic step(input logic [1:0] m, input logic wr, input logic [3:0] a,
                      input logic [31:0] d, input logic rd_chk);
    exp_t e;
    logic g;
    logic [31:0] erd;
    @(negedge clk);
    op_mode = m; reg_wr = wr; reg_addr = a; reg_wdata = d;
    g   = sh_gate[(m == 2'd3) ? 2 : int'(m)];           // R1
    e.c = g;                                            // R2 R3 R4
    e.p = g | sh_ret;
    e.r = e.p & ~prev_p;                                // R5
    prev_p = e.p;
    exp_q.push_back(e);
    erd = (a == 4'd0) ? {29'd0, sh_gate} : (a == 4'd1) ? {31'd0, sh_ret} : 32'd0;
    if (rd_chk) begin
      #1;
      chk("R6/R7 rdata", reg_rdata, erd);
    end
    if (wr) begin
      if (a == 4'd0) sh_gate = d[2:0];
      if (a == 4'd1) sh_ret  = d[0];
    end
  endtask

  task automatic idle(input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) step(m, 1'b0, 4'd0, 32'd0, 1'b0);
  endtask

  // Monitor: pops one expected item per clock edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R2/R3/R4/R10 pwr_en", {31'd0, pwr_en}, {31'd0, e.p});
      chk("R2/R3/R4/R9 clk_en", {31'd0, clk_en}, {31'd0, e.c});
      chk("R5 per_rst", {31'd0, per_rst}, {31'd0, e.r});
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 pwr_en in reset", {31'd0, pwr_en}, 32'd1);
    chk("R8 clk_en in reset", {31'd0, clk_en}, 32'd0);
    chk("R8 per_rst in reset", {31'd0, per_rst}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(2'd0, 1'b0, 4'd0, 32'd0, 1'b1);                 // R7 gate reset 0
    step(2'd0, 1'b0, 4'd1, 32'd0, 1'b1);                 // R6 retain reset 1
    idle(2'd0, 2);                                       // R8 after release
    // R2: run bit set, clocked regardless of retain
    step(2'd0, 1'b1, 4'd0, 32'h1, 1'b0);
    step(2'd0, 1'b1, 4'd1, 32'h0, 1'b0);
    idle(2'd0, 2);
    // R3: move to sleep and deep modes with gate 0 and retain 0
    idle(2'd1, 2);
    idle(2'd2, 2);
    idle(2'd3, 2);
    // R1 R5: back to run restores power with one pulse
    idle(2'd0, 3);
    // R4: retain set, then sleep
    step(2'd0, 1'b1, 4'd1, 32'h1, 1'b0);
    idle(2'd1, 3);
    // R5: power lost by write, restored by write
    step(2'd1, 1'b1, 4'd1, 32'h0, 1'b0);
    idle(2'd1, 2);
    step(2'd1, 1'b1, 4'd1, 32'h1, 1'b0);
    idle(2'd1, 3);
    // R1: code 3 uses deep-sleep bit
    step(2'd1, 1'b1, 4'd0, 32'h4, 1'b1);
    step(2'd1, 1'b1, 4'd1, 32'h0, 1'b0);
    idle(2'd3, 2);
    idle(2'd2, 2);
    idle(2'd0, 2);
    idle(2'd3, 2);
    // R6 R7: reserved bits ignored
    step(2'd3, 1'b1, 4'd1, 32'hFFFF_FFFE, 1'b0);
    step(2'd3, 1'b0, 4'd1, 32'd0, 1'b1);
    step(2'd3, 1'b1, 4'd1, 32'hFFFF_FFFF, 1'b0);
    step(2'd3, 1'b0, 4'd1, 32'd0, 1'b1);
    step(2'd3, 1'b1, 4'd0, 32'hFFFF_FFFA, 1'b0);
    step(2'd3, 1'b0, 4'd0, 32'd0, 1'b1);
    // R7: unmapped address write has no effect
    step(2'd3, 1'b1, 4'd7, 32'hFFFF_FFFF, 1'b1);
    step(2'd3, 1'b0, 4'd0, 32'd0, 1'b1);
    step(2'd3, 1'b0, 4'd1, 32'd0, 1'b1);
    // R5 corner: mode change and retain write restore power in one cycle
    step(2'd1, 1'b1, 4'd1, 32'h0, 1'b0);
    step(2'd1, 1'b1, 4'd0, 32'h1, 1'b0);
    idle(2'd1, 2);
    step(2'd0, 1'b1, 4'd1, 32'h1, 1'b0);
    idle(2'd0, 3);
    // R5 corner: mode cuts power while retain write lands
    step(2'd0, 1'b1, 4'd1, 32'h0, 1'b0);
    idle(2'd0, 1);
    step(2'd1, 1'b1, 4'd1, 32'h1, 1'b0);
    idle(2'd1, 3);
    idle(2'd1, 2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule